// File: doc/BRIEF.md
# Per-Flow Resequencing Output Buffer

This block is the buffer at one output port after the second switching stage of a load-balanced two-stage packet switch. The middle stage spreads the packets of a flow across several paths, so they reach the output port out of order. Each arriving packet carries a flow number and a per-flow sequence number. The block holds a packet until every earlier packet of its flow has been released. It then moves the packet into an output queue, which feeds the output link at no more than one fixed-size packet per time slot.

Each flow has a register holding the sequence number it expects next. When an arriving packet carries that number and the output queue has room, the block releases it at once. A packet that arrives early, within a window of `WIN` sequence numbers, is parked in a per-flow slot chosen by the low bits of its sequence number. Once the gap in front of it fills, the parked packets of that flow drain into the queue one per cycle, in sequence order. A packet that has no free slot is dropped, and the block raises a one-cycle overflow flag. The designer sizes `WIN` and `OQ_DEPTH` from the occupancy bound of the switch: (N+1)·Mmax for FCFS with jitter control, or N·(Lmax+Mmax) for earliest-deadline central buffers. Here N is the switch size, Mmax the most flows at one output and Lmax the most flows at one input.

Top module: `rsq_output_buffer`

## Requirements
- R1: After reset, every flow expects sequence number 0, all reorder slots and the output queue are empty, `out_valid` is 0 and `overflow` is 0.
- R2: An arriving packet whose sequence number equals its flow's expected value is written into the output queue at the clock edge that samples it. This happens when the queue is not full and nothing is parked at that number. `out_valid` is high from that edge on.
- R3: An arriving packet whose offset (sequence minus expected, modulo 2^SEQ_W) lies in 1..WIN-1 is parked in slot `seq mod WIN` of its flow. It does not reach the output until its offset becomes 0.
- R4: When a flow's expected number matches a parked packet, that packet enters the queue one cycle after the expected number advanced. Parked successors follow one per cycle in sequence order.
- R5: A packet whose offset is WIN or more, or whose slot is already occupied, is dropped without changing the expected number. `overflow` is 1 in the cycle after it was sampled and 0 otherwise.
- R6: While `out_valid` is 1 and `link_ready` is 0, the head packet's flow, sequence and data stay unchanged. One packet leaves on each edge where both are 1.
- R7: Packets leave the link port in the order they were released. Within a flow, the sequence numbers seen at the link port increase by one, modulo 2^SEQ_W.
- R8: Only one packet can enter the queue per cycle. A direct release of an arriving packet takes priority over draining a parked packet. Among flows with a parked packet ready, the lowest flow number drains first.
- R9: Sequence numbers wrap modulo 2^SEQ_W. After sequence 2^SEQ_W-1 a flow expects 0, and offsets are computed modulo 2^SEQ_W.
- R10: When the output queue holds OQ_DEPTH packets, an in-order arrival is parked (offset 0) rather than dropped. It is released once the link frees a queue entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-slot clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A packet arrives this cycle |
| in_flow | input | FLOW_W | Flow number of the arriving packet |
| in_seq | input | SEQ_W | Per-flow sequence number of the arriving packet |
| in_data | input | DATA_W | Packet payload |
| link_ready | input | 1 | Output link takes the head packet this slot |
| out_valid | output | 1 | Output queue holds a packet |
| out_flow | output | FLOW_W | Flow number of the head packet |
| out_seq | output | SEQ_W | Sequence number of the head packet |
| out_data | output | DATA_W | Payload of the head packet |
| overflow | output | 1 | A packet was dropped for want of a reorder slot last cycle |

## Verification
A direct release shows at the link port after the same edge that samples the arrival, so the bench checks it at the falling edge that follows. A parked packet needs one more edge after its gap fills, so its successors appear on consecutive falling edges after that. The overflow flag is registered and so is checked exactly one edge after the bad arrival, then checked again one edge later to confirm it has cleared. Every packet leaving the link port is compared against a per-flow expected sequence and a payload computed from flow and sequence. This comparison is made 1 ns before the rising edge that pops the packet, when the inputs have settled.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    localparam int FLOW_W = 2;
    localparam int SEQ_W  = 4;
    localparam int DATA_W = 8;

    typedef logic [FLOW_W-1:0] flow_t;
    typedef logic [SEQ_W-1:0]  seq_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        flow_t flow;
        seq_t  seq;
        data_t data;
    } pkt_t;

    // Distance of a sequence number ahead of the expected one, modulo 2^SEQ_W.
    function automatic seq_t seq_offset(input seq_t seq, input seq_t expect_seq);
        return seq - expect_seq;
    endfunction

    function automatic seq_t seq_next(input seq_t seq);
        return seq + seq_t'(1);
    endfunction

endpackage

// File: rtl/rsq_flow_ctx.sv
module rsq_flow_ctx
    import rsq_pkg::*;
#(
    parameter int WIN = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  arr_valid,
    input  seq_t  arr_seq,
    input  data_t arr_data,
    input  logic  arr_direct,
    input  logic  drain_grant,
    output seq_t  exp_seq,
    output logic  head_valid,
    output data_t head_data,
    output logic  drop
);

    localparam int IDX_W = (WIN > 1) ? $clog2(WIN) : 1;

    seq_t             exp_q;
    logic [WIN-1:0]   slot_v;
    data_t            slot_d [WIN];
    logic [IDX_W-1:0] arr_idx;
    logic [IDX_W-1:0] head_idx;
    seq_t             arr_off;
    logic             park;

    assign arr_idx  = arr_seq[IDX_W-1:0];
    assign head_idx = exp_q[IDX_W-1:0];
    assign arr_off  = seq_offset(arr_seq, exp_q);

    assign park = arr_valid && !arr_direct
                  && (arr_off < seq_t'(WIN)) && !slot_v[arr_idx];
    assign drop = arr_valid && !arr_direct && !park;

    assign exp_seq    = exp_q;
    assign head_valid = slot_v[head_idx];
    assign head_data  = slot_d[head_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q  <= '0;
            slot_v <= '0;
        end else begin
            if (arr_direct || drain_grant) begin
                exp_q <= seq_next(exp_q);
            end
            if (drain_grant) begin
                slot_v[head_idx] <= 1'b0;
            end
            if (park) begin
                slot_v[arr_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (park) begin
            slot_d[arr_idx] <= arr_data;
        end
    end

endmodule

// File: rtl/rsq_out_fifo.sv
module rsq_out_fifo
    import rsq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  pkt_t wr_pkt,
    input  logic rd_en,
    output logic full,
    output logic valid,
    output pkt_t rd_pkt
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    pkt_t          mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [AW:0]   cnt;
    logic          do_wr;
    logic          do_rd;

    assign full   = (cnt == (AW+1)'(DEPTH));
    assign valid  = (cnt != '0);
    assign rd_pkt = mem[rp];
    assign do_wr  = wr_en && !full;
    assign do_rd  = rd_en && valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= wp + AW'(1);
            if (do_rd) rp <= rp + AW'(1);
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + (AW+1)'(1);
                2'b01:   cnt <= cnt - (AW+1)'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wp] <= wr_pkt;
        end
    end

endmodule

// File: rtl/rsq_output_buffer.sv
module rsq_output_buffer
    import rsq_pkg::*;
#(
    parameter int WIN      = 4,
    parameter int OQ_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [FLOW_W-1:0] in_flow,
    input  logic [SEQ_W-1:0]  in_seq,
    input  logic [DATA_W-1:0] in_data,
    input  logic              link_ready,
    output logic              out_valid,
    output logic [FLOW_W-1:0] out_flow,
    output logic [SEQ_W-1:0]  out_seq,
    output logic [DATA_W-1:0] out_data,
    output logic              overflow
);

    localparam int NUM_FLOWS = 1 << FLOW_W;

    seq_t                 exp_seq   [NUM_FLOWS];
    data_t                head_data [NUM_FLOWS];
    logic [NUM_FLOWS-1:0] head_valid;
    logic [NUM_FLOWS-1:0] drop_vec;
    logic [NUM_FLOWS-1:0] dir_vec;
    logic [NUM_FLOWS-1:0] grant;
    flow_t                gidx;
    logic                 direct;
    logic                 oq_full;
    logic                 wr_en;
    pkt_t                 wr_pkt;
    pkt_t                 head_pkt;
    logic                 ovf_q;

    assign direct = in_valid && (in_seq == exp_seq[in_flow])
                    && !head_valid[in_flow] && !oq_full;

    // Lowest-numbered flow with a ready parked packet wins the queue write.
    always_comb begin
        grant = '0;
        gidx  = '0;
        if (!direct && !oq_full) begin
            for (int f = NUM_FLOWS - 1; f >= 0; f--) begin
                if (head_valid[f]) begin
                    grant    = '0;
                    grant[f] = 1'b1;
                    gidx     = flow_t'(f);
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_FLOWS; g++) begin : g_flow
            assign dir_vec[g] = direct && (in_flow == flow_t'(g));

            rsq_flow_ctx #(.WIN(WIN)) ctx_i (
                .clk         (clk),
                .rst         (rst),
                .arr_valid   (in_valid && (in_flow == flow_t'(g))),
                .arr_seq     (in_seq),
                .arr_data    (in_data),
                .arr_direct  (dir_vec[g]),
                .drain_grant (grant[g]),
                .exp_seq     (exp_seq[g]),
                .head_valid  (head_valid[g]),
                .head_data   (head_data[g]),
                .drop        (drop_vec[g])
            );
        end
    endgenerate

    assign wr_en = direct || (grant != '0);

    always_comb begin
        if (direct) begin
            wr_pkt = '{flow: in_flow, seq: in_seq, data: in_data};
        end else begin
            wr_pkt = '{flow: gidx, seq: exp_seq[gidx], data: head_data[gidx]};
        end
    end

    rsq_out_fifo #(.DEPTH(OQ_DEPTH)) oq_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_pkt (wr_pkt),
        .rd_en  (link_ready),
        .full   (oq_full),
        .valid  (out_valid),
        .rd_pkt (head_pkt)
    );

    assign out_flow = head_pkt.flow;
    assign out_seq  = head_pkt.seq;
    assign out_data = head_pkt.data;

    always_ff @(posedge clk) begin
        if (rst) ovf_q <= 1'b0;
        else     ovf_q <= |drop_vec;
    end

    assign overflow = ovf_q;

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker
    import rsq_pkg::*;
#(
    parameter int NUM_FLOWS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 link_ready,
    input logic                 out_valid,
    input logic [FLOW_W-1:0]    out_flow,
    input logic [SEQ_W-1:0]     out_seq,
    input logic [DATA_W-1:0]    out_data,
    input logic                 overflow,
    input logic                 wr_en,
    input logic                 oq_full,
    input logic [NUM_FLOWS-1:0] grant
);

    logic [NUM_FLOWS-1:0] seen;
    seq_t                 last_seq [NUM_FLOWS];
    logic                 pop;

    assign pop = out_valid && link_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= '0;
        end else if (pop) begin
            seen[out_flow]     <= 1'b1;
            last_seq[out_flow] <= out_seq;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !overflow));

    p_write_shows_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> out_valid);

    p_overflow_cause_r5: assert property (@(posedge clk) disable iff (rst)
        overflow |-> $past(in_valid));

    p_head_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !link_ready) |=>
            (out_valid && $stable(out_flow) && $stable(out_seq) && $stable(out_data)));

    p_flow_order_r7: assert property (@(posedge clk) disable iff (rst)
        (pop && seen[out_flow]) |-> (out_seq == seq_next(last_seq[out_flow])));

    p_single_drain_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_full_stays_r10: assert property (@(posedge clk) disable iff (rst)
        (oq_full && !link_ready) |=> oq_full);

endmodule

bind rsq_output_buffer rsq_checker #(.NUM_FLOWS(NUM_FLOWS)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .link_ready (link_ready),
    .out_valid  (out_valid),
    .out_flow   (out_flow),
    .out_seq    (out_seq),
    .out_data   (out_data),
    .overflow   (overflow),
    .wr_en      (wr_en),
    .oq_full    (oq_full),
    .grant      (grant)
);

// File: tb/rsq_output_buffer_tb.sv
`timescale 1ns/1ps
module rsq_output_buffer_tb_top;
    import rsq_pkg::*;

    localparam int WIN = 4;
    localparam int OQ_DEPTH = 8;
    localparam int NSEQ = 1 << SEQ_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [FLOW_W-1:0] in_flow = '0;
    logic [SEQ_W-1:0]  in_seq = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic              link_ready = 1'b0;
    logic              out_valid;
    logic [FLOW_W-1:0] out_flow;
    logic [SEQ_W-1:0]  out_seq;
    logic [DATA_W-1:0] out_data;
    logic              overflow;

    int checks = 0;
    int failures = 0;
    int pops = 0;
    int mon_exp [4] = '{0, 0, 0, 0};
    bit done = 1'b0;

    always #2 clk = ~clk;

    rsq_output_buffer #(.WIN(WIN), .OQ_DEPTH(OQ_DEPTH)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_flow(in_flow),
        .in_seq(in_seq), .in_data(in_data), .link_ready(link_ready),
        .out_valid(out_valid), .out_flow(out_flow), .out_seq(out_seq),
        .out_data(out_data), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    task automatic drive(input int f, input int s);
        in_valid = 1'b1;
        in_flow  = FLOW_W'(f);
        in_seq   = SEQ_W'(s);
        in_data  = DATA_W'(f * 16 + s);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic head_is(input int f, input int s, input string what);
        chk(out_valid == 1'b1, {what, " valid"}, int'(out_valid), 1);
        chk(out_flow == FLOW_W'(f), {what, " flow"}, int'(out_flow), f);
        chk(out_seq == SEQ_W'(s), {what, " seq"}, int'(out_seq), s);
    endtask

    // R7: link-port monitor, sampled 1 ns before the popping edge
    always @(negedge clk) begin
        #1;
        if (!rst && out_valid && link_ready) begin
            chk(int'(out_seq) == mon_exp[out_flow], "R7 per-flow order",
                int'(out_seq), mon_exp[out_flow]);
            chk(out_data == DATA_W'(int'(out_flow) * 16 + int'(out_seq)),
                "R7 payload", int'(out_data), int'(out_flow) * 16 + int'(out_seq));
            mon_exp[out_flow] = (mon_exp[out_flow] + 1) % NSEQ;
            pops++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(overflow == 1'b0, "R1 overflow after reset", int'(overflow), 0);

        // R2 direct release, R6 hold while link stalls
        drive(0, 0);
        head_is(0, 0, "R2 direct release");
        repeat (2) @(negedge clk);
        head_is(0, 0, "R6 head held");
        chk(out_data == 8'd0, "R6 data held", int'(out_data), 0);
        link_ready = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 one pop", int'(out_valid), 0);

        // R3 early packets parked, R4 drained in order
        drive(1, 2);
        chk(out_valid == 1'b0, "R3 early seq2 parked", int'(out_valid), 0);
        drive(1, 1);
        chk(out_valid == 1'b0, "R3 early seq1 parked", int'(out_valid), 0);
        drive(1, 0);
        head_is(1, 0, "R2 gap filler");
        @(negedge clk);
        head_is(1, 1, "R4 drain first");
        @(negedge clk);
        head_is(1, 2, "R4 drain second");
        @(negedge clk);
        chk(out_valid == 1'b0, "R4 drained empty", int'(out_valid), 0);

        // R5 overflow: out of window, then duplicate slot
        drive(2, 4);
        chk(overflow == 1'b1, "R5 out-of-window flag", int'(overflow), 1);
        @(negedge clk);
        chk(overflow == 1'b0, "R5 flag one cycle", int'(overflow), 0);
        chk(out_valid == 1'b0, "R5 dropped not sent", int'(out_valid), 0);
        drive(2, 1);
        chk(overflow == 1'b0, "R5 in-window no flag", int'(overflow), 0);
        drive(2, 1);
        chk(overflow == 1'b1, "R5 duplicate flag", int'(overflow), 1);
        drive(2, 0);
        head_is(2, 0, "R5 flow2 seq0");
        @(negedge clk);
        head_is(2, 1, "R5 flow2 seq1");
        @(negedge clk);
        chk(out_valid == 1'b0, "R5 seq4 ignored", int'(out_valid), 0);
        drive(2, 2);
        head_is(2, 2, "R5 expected unchanged");
        @(negedge clk);

        // R8 priority: direct beats drain, lowest flow drains first
        link_ready = 1'b0;
        drive(3, 1);
        drive(0, 2);
        drive(3, 0);
        drive(0, 1);
        repeat (2) @(negedge clk);
        link_ready = 1'b1;
        head_is(3, 0, "R8 slot0");
        @(negedge clk);
        head_is(0, 1, "R8 direct beat drain");
        @(negedge clk);
        head_is(0, 2, "R8 lowest flow first");
        @(negedge clk);
        head_is(3, 1, "R8 higher flow last");
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 empty", int'(out_valid), 0);

        // R10 queue full: in-order arrival parked
        link_ready = 1'b0;
        for (int s = 3; s <= 10; s++) drive(1, s);
        drive(1, 11);
        chk(overflow == 1'b0, "R10 no drop when full", int'(overflow), 0);
        @(negedge clk);
        link_ready = 1'b1;
        for (int k = 0; k < 9; k++) begin
            head_is(1, 3 + k, "R10 full drain");
            @(negedge clk);
        end
        chk(out_valid == 1'b0, "R10 empty", int'(out_valid), 0);

        // R9 wrap-around
        for (int s = 3; s < NSEQ; s++) drive(0, s);
        drive(0, 1);
        chk(out_valid == 1'b0, "R9 seq1 parked after wrap", int'(out_valid), 0);
        drive(0, 0);
        head_is(0, 0, "R9 wrapped seq0");
        @(negedge clk);
        head_is(0, 1, "R9 wrapped seq1");
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 empty", int'(out_valid), 0);

        repeat (4) @(negedge clk);
        chk(pops == 35, "R7 total packets", pops, 35);
        chk(mon_exp[0] == 2, "R7 flow0 count", mon_exp[0], 2);
        chk(mon_exp[1] == 12, "R7 flow1 count", mon_exp[1], 12);
        chk(mon_exp[2] == 3, "R7 flow2 count", mon_exp[2], 3);
        chk(mon_exp[3] == 2, "R7 flow3 count", mon_exp[3], 2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule